// File: doc/BRIEF.md
# Next-PC Resolution Unit

This unit resolves control flow for a 32-bit integer core whose instructions are normally 4 bytes long and naturally aligned. Each cycle it takes the current program counter, the fetched instruction word and the two source register values. From these it decides whether the instruction redirects the flow, and which address is fetched next.

It handles three kinds of control transfer. A conditional branch compares the two registers in one of six ways and adds a PC-relative offset. A direct jump adds a PC-relative offset of about ±1 MB. An indirect jump adds a 12-bit offset to the first register. Each offset has its bits scattered through the instruction word, and the unit puts them back together. It also produces the return address that a jump writes to its link register, and it flags any taken target that the fetch unit cannot reach.

All results are registered and appear one clock after the inputs. A parameter states whether the core also fetches 2-byte instructions. That setting controls whether a target that is only halfword aligned is legal.

Top module: `bju_next_pc`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to zero after that edge.
- R2: Any instruction that is not a branch (opcode 1100011), a direct jump (opcode 1101111) or an indirect jump (opcode 1100111 with bits 14:12 equal to 000) gives `next_pc_o` = PC+4 with `taken_o` and `link_en_o` low. This includes an indirect-jump opcode with nonzero bits 14:12.
- R3: For a branch, bits 14:12 choose the test on rs1 and rs2: 000 equal, 001 not equal, 100 signed less than, 101 signed greater or equal, 110 unsigned less than, 111 unsigned greater or equal. The codes 010 and 011 are never taken. A branch that is not taken gives PC+4 with `link_en_o` low.
- R4: A taken branch targets PC plus a sign-extended 13-bit offset. Offset bit 12 comes from instruction bit 31, bit 11 from bit 7, bits 10:5 from bits 30:25 and bits 4:1 from bits 11:8. Offset bit 0 is zero.
- R5: A direct jump is always taken. Its target is PC plus a sign-extended 21-bit offset. Offset bit 20 comes from instruction bit 31, bits 19:12 from bits 19:12, bit 11 from bit 20 and bits 10:1 from bits 30:21. Offset bit 0 is zero. `link_en_o` is high.
- R6: An indirect jump is always taken. Its target is rs1 plus the sign-extended instruction bits 31:20, with bit 0 of the sum forced to zero. `link_en_o` is high.
- R7: `link_pc_o` always equals the registered PC plus 4, whatever the instruction.
- R8: With `HALF_FETCH`=0, a transfer that would be taken but whose target has bit 1 set raises `misalign_o`. In that case `taken_o` and `link_en_o` are low and `next_pc_o` is PC+4.
- R9: With `HALF_FETCH`=1, a target that is only halfword aligned is taken normally and `misalign_o` stays low.
- R10: Each output reflects the inputs that were present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the current instruction |
| inst_i | input | 32 | Current instruction word |
| rs1_i | input | 32 | First source register value |
| rs2_i | input | 32 | Second source register value |
| next_pc_o | output | 32 | Address to fetch next |
| taken_o | output | 1 | Flow was redirected to a computed target |
| link_en_o | output | 1 | The link value should be written back (jumps only) |
| link_pc_o | output | 32 | PC+4 return address |
| misalign_o | output | 1 | Taken target violates fetch alignment |

## Verification
Every result is due exactly one rising edge after the inputs it belongs to. The driver applies one instruction on each falling edge and queues its expected outcome. The monitor samples 1 ns after the following rising edge, so each queued item meets the register output of that same instruction and nothing is read while it is changing. The reset state is sampled in the same way after a rising edge taken with reset held high.

// File: rtl/bju_pkg.sv
package bju_pkg;

    localparam int unsigned XW = 32;

    localparam logic [6:0] OP_BRANCH = 7'b1100011;
    localparam logic [6:0] OP_JAL    = 7'b1101111;
    localparam logic [6:0] OP_JALR   = 7'b1100111;

    typedef enum logic [1:0] {
        K_SEQ  = 2'd0,
        K_BR   = 2'd1,
        K_JAL  = 2'd2,
        K_JALR = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        C_EQ  = 3'b000,
        C_NE  = 3'b001,
        C_LT  = 3'b100,
        C_GE  = 3'b101,
        C_LTU = 3'b110,
        C_GEU = 3'b111
    } cond_e;

    typedef struct packed {
        logic [XW-1:0] next_pc;
        logic          taken;
        logic          link_en;
        logic [XW-1:0] link_pc;
        logic          misalign;
    } res_t;

    function automatic logic [XW-1:0] imm_branch(input logic [31:0] w);
        return {{(XW-12){w[31]}}, w[7], w[30:25], w[11:8], 1'b0};
    endfunction

    function automatic logic [XW-1:0] imm_jump(input logic [31:0] w);
        return {{(XW-20){w[31]}}, w[19:12], w[20], w[30:21], 1'b0};
    endfunction

    function automatic logic [XW-1:0] imm_reg(input logic [31:0] w);
        return {{(XW-12){w[31]}}, w[31:20]};
    endfunction

endpackage

// File: rtl/bju_decode.sv
module bju_decode
    import bju_pkg::*;
(
    input  logic [6:0] opcode_i,
    input  logic [2:0] f3_i,
    output kind_e      kind_o
);
    always_comb begin
        kind_o = K_SEQ;
        if (opcode_i == OP_BRANCH)                     kind_o = K_BR;
        else if (opcode_i == OP_JAL)                   kind_o = K_JAL;
        else if (opcode_i == OP_JALR && f3_i == 3'b000) kind_o = K_JALR;
    end
endmodule

// File: rtl/bju_cmp.sv
module bju_cmp
    import bju_pkg::*;
(
    input  logic [XW-1:0] a_i,
    input  logic [XW-1:0] b_i,
    input  logic [2:0]    f3_i,
    output logic          hit_o
);
    logic eq, lt_s, lt_u;

    assign eq   = (a_i == b_i);
    assign lt_s = ($signed(a_i) < $signed(b_i));
    assign lt_u = (a_i < b_i);

    always_comb begin
        case (f3_i)
            C_EQ:    hit_o = eq;
            C_NE:    hit_o = !eq;
            C_LT:    hit_o = lt_s;
            C_GE:    hit_o = !lt_s;
            C_LTU:   hit_o = lt_u;
            C_GEU:   hit_o = !lt_u;
            default: hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/bju_target.sv
module bju_target
    import bju_pkg::*;
(
    input  kind_e         kind_i,
    input  logic [XW-1:0] pc_i,
    input  logic [31:0]   inst_i,
    input  logic [XW-1:0] rs1_i,
    output logic [XW-1:0] tgt_o
);
    logic [XW-1:0] base, offs, sum;

    always_comb begin
        base = pc_i;
        offs = imm_branch(inst_i);
        case (kind_i)
            K_JAL:   offs = imm_jump(inst_i);
            K_JALR: begin
                base = rs1_i;
                offs = imm_reg(inst_i);
            end
            default: ;
        endcase
    end

    assign sum   = base + offs;
    assign tgt_o = (kind_i == K_JALR) ? {sum[XW-1:1], 1'b0} : sum;
endmodule

// File: rtl/bju_next_pc.sv
module bju_next_pc
    import bju_pkg::*;
#(
    parameter bit HALF_FETCH = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [31:0]   pc_i,
    input  logic [31:0]   inst_i,
    input  logic [31:0]   rs1_i,
    input  logic [31:0]   rs2_i,
    output logic [31:0]   next_pc_o,
    output logic          taken_o,
    output logic          link_en_o,
    output logic [31:0]   link_pc_o,
    output logic          misalign_o
);
    kind_e         kind;
    logic          cond_hit;
    logic [XW-1:0] tgt;
    logic [XW-1:0] seq_pc;
    logic          want;
    logic          bad;
    res_t          d, q;
    logic          primed;

    bju_decode u_dec (
        .opcode_i (inst_i[6:0]),
        .f3_i     (inst_i[14:12]),
        .kind_o   (kind)
    );

    bju_cmp u_cmp (
        .a_i   (rs1_i),
        .b_i   (rs2_i),
        .f3_i  (inst_i[14:12]),
        .hit_o (cond_hit)
    );

    bju_target u_tgt (
        .kind_i (kind),
        .pc_i   (pc_i),
        .inst_i (inst_i),
        .rs1_i  (rs1_i),
        .tgt_o  (tgt)
    );

    assign seq_pc = pc_i + 32'd4;
    assign want   = (kind == K_JAL) || (kind == K_JALR) || ((kind == K_BR) && cond_hit);

    generate
        if (HALF_FETCH) begin : g_half
            assign bad = 1'b0;
        end else begin : g_word
            assign bad = want && tgt[1];
        end
    endgenerate

    always_comb begin
        d.taken    = want && !bad;
        d.next_pc  = d.taken ? tgt : seq_pc;
        d.link_en  = ((kind == K_JAL) || (kind == K_JALR)) && !bad;
        d.link_pc  = seq_pc;
        d.misalign = bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q      <= '0;
            primed <= 1'b0;
        end else begin
            q      <= d;
            primed <= 1'b1;
        end
    end

    assign next_pc_o  = q.next_pc;
    assign taken_o    = q.taken;
    assign link_en_o  = q.link_en;
    assign link_pc_o  = q.link_pc;
    assign misalign_o = q.misalign;

    a_r7_link_value: assert property (@(posedge clk) disable iff (rst)
        primed |-> link_pc_o == $past(pc_i) + 32'd4);

    a_r8_fault_blocks_redirect: assert property (@(posedge clk) disable iff (rst)
        primed && misalign_o |-> !taken_o && !link_en_o && next_pc_o == link_pc_o);

    a_r5_jump_taken: assert property (@(posedge clk) disable iff (rst)
        primed && $past(inst_i[6:0]) == OP_JAL && !misalign_o |-> taken_o && link_en_o);

    a_r2_plain_sequential: assert property (@(posedge clk) disable iff (rst)
        primed && $past(inst_i[6:0]) != OP_JAL && $past(inst_i[6:0]) != OP_JALR
               && $past(inst_i[6:0]) != OP_BRANCH
        |-> !taken_o && !link_en_o && !misalign_o && next_pc_o == link_pc_o);

    a_r3_equal_taken: assert property (@(posedge clk) disable iff (rst)
        primed && $past(inst_i[6:0]) == OP_BRANCH && $past(inst_i[14:12]) == 3'b000
               && $past(rs1_i) == $past(rs2_i) && !misalign_o |-> taken_o);

    a_r9_half_never_faults: assert property (@(posedge clk) disable iff (rst)
        primed && HALF_FETCH |-> !misalign_o);

endmodule

// File: tb/bju_next_pc_test.sv
`timescale 1ns/1ps
module bju_next_pc_test;

    typedef struct packed {
        logic [31:0] next_pc;
        logic        taken;
        logic        link_en;
        logic [31:0] link_pc;
        logic        misalign;
    } exp_t;

    typedef struct {
        exp_t  w;
        exp_t  h;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc = '0, inst = 32'h13, rs1 = '0, rs2 = '0;

    logic [31:0] npc_w, lpc_w, npc_h, lpc_h;
    logic        tk_w, le_w, mis_w, tk_h, le_h, mis_h;

    int checks = 0;
    int fails  = 0;
    item_t sbq[$];

    always #2.5 clk = ~clk;

    bju_next_pc #(.HALF_FETCH(1'b0)) uut (
        .clk(clk), .rst(rst), .pc_i(pc), .inst_i(inst), .rs1_i(rs1), .rs2_i(rs2),
        .next_pc_o(npc_w), .taken_o(tk_w), .link_en_o(le_w), .link_pc_o(lpc_w),
        .misalign_o(mis_w)
    );

    bju_next_pc #(.HALF_FETCH(1'b1)) uut_half (
        .clk(clk), .rst(rst), .pc_i(pc), .inst_i(inst), .rs1_i(rs1), .rs2_i(rs2),
        .next_pc_o(npc_h), .taken_o(tk_h), .link_en_o(le_h), .link_pc_o(lpc_h),
        .misalign_o(mis_h)
    );

    function automatic logic [31:0] enc_b(input logic [12:0] off, input logic [2:0] f3);
        return {off[12], off[10:5], 5'd2, 5'd1, f3, off[4:1], off[11], 7'b1100011};
    endfunction

    function automatic logic [31:0] enc_j(input logic [20:0] off);
        return {off[20], off[10:1], off[11], off[19:12], 5'd1, 7'b1101111};
    endfunction

    function automatic logic [31:0] enc_r(input logic [11:0] imm, input logic [2:0] f3);
        return {imm, 5'd3, f3, 5'd1, 7'b1100111};
    endfunction

    // kind: 0 sequential, 1 branch, 2 direct jump, 3 indirect jump
    function automatic exp_t model(input int kind, input logic [2:0] f3, input logic [31:0] p,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic [31:0] off, input bit half);
        exp_t e;
        logic go, lnk;
        logic [31:0] t;
        go = 1'b0; lnk = 1'b0; t = p + off;
        case (kind)
            1: case (f3)
                   3'b000: go = (a == b);
                   3'b001: go = (a != b);
                   3'b100: go = ($signed(a) < $signed(b));
                   3'b101: go = !($signed(a) < $signed(b));
                   3'b110: go = (a < b);
                   3'b111: go = !(a < b);
                   default: go = 1'b0;
               endcase
            2: begin go = 1'b1; lnk = 1'b1; end
            3: begin go = 1'b1; lnk = 1'b1; t = (a + off) & ~32'd1; end
            default: ;
        endcase
        e.link_pc  = p + 32'd4;
        e.misalign = go && !half && t[1];
        e.taken    = go && !e.misalign;
        e.link_en  = lnk && !e.misalign;
        e.next_pc  = e.taken ? t : p + 32'd4;
        return e;
    endfunction

    task automatic drive(input logic [31:0] p, input logic [31:0] w, input logic [31:0] a,
                         input logic [31:0] b, input int kind, input logic [31:0] off,
                         input string tag);
        item_t it;
        @(negedge clk);
        pc = p; inst = w; rs1 = a; rs2 = b;
        it.w   = model(kind, w[14:12], p, a, b, off, 1'b0);
        it.h   = model(kind, w[14:12], p, a, b, off, 1'b1);
        it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic cmp_one(input exp_t got, input exp_t ex, input string tag, input string who);
        checks++;
        if (got !== ex) begin
            fails++;
            $display("FAIL %s (%s): got npc=%h tk=%b le=%b lpc=%h mis=%b exp npc=%h tk=%b le=%b lpc=%h mis=%b",
                     tag, who, got.next_pc, got.taken, got.link_en, got.link_pc, got.misalign,
                     ex.next_pc, ex.taken, ex.link_en, ex.link_pc, ex.misalign);
        end
    endtask

    // Monitor: R10 one-cycle latency, sampled 1 ns after the rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sbq.size() > 0) begin
                item_t it;
                it = sbq.pop_front();
                cmp_one({npc_w, tk_w, le_w, lpc_w, mis_w}, it.w, it.tag, "word");
                cmp_one({npc_h, tk_h, le_h, lpc_h, mis_h}, it.h, it.tag, "half");
            end
        end
    end

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: got hang expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        cmp_one({npc_w, tk_w, le_w, lpc_w, mis_w}, '0, "R1 reset", "word");
        cmp_one({npc_h, tk_h, le_h, lpc_h, mis_h}, '0, "R1 reset", "half");
        @(negedge clk);
        rst = 1'b0;

        // R2 / R7: sequential instructions
        drive(32'h0000_1000, 32'h0000_0013, 1, 2, 0, 0, "R2 R7 addi");
        drive(32'h0000_2000, enc_r(12'h010, 3'b001), 32'h100, 0, 0, 0, "R2 jalr bad funct3");
        drive(32'hFFFF_FFFC, 32'h0000_0033, 0, 0, 0, 0, "R7 wrap");

        // R3: six conditions, both outcomes, plus illegal codes
        drive(32'h100, enc_b(13'd16, 3'b000), 5, 5, 1, 16, "R3 R4 beq taken");
        drive(32'h100, enc_b(13'd16, 3'b000), 5, 6, 1, 16, "R3 beq not taken");
        drive(32'h100, enc_b(13'd32, 3'b001), 5, 6, 1, 32, "R3 bne taken");
        drive(32'h100, enc_b(13'd32, 3'b001), 7, 7, 1, 32, "R3 bne not taken");
        drive(32'h200, enc_b(13'd8, 3'b100), 32'hFFFF_FFFF, 1, 1, 8, "R3 blt signed");
        drive(32'h200, enc_b(13'd8, 3'b110), 32'hFFFF_FFFF, 1, 1, 8, "R3 bltu unsigned");
        drive(32'h200, enc_b(13'd8, 3'b101), 3, 3, 1, 8, "R3 bge equal");
        drive(32'h200, enc_b(13'd8, 3'b111), 0, 1, 1, 8, "R3 bgeu not taken");
        drive(32'h200, enc_b(13'd8, 3'b010), 0, 0, 1, 8, "R3 code 010");
        drive(32'h200, enc_b(13'd8, 3'b011), 0, 0, 1, 8, "R3 code 011");

        // R4: branch offset extremes
        drive(32'h0001_0000, enc_b(13'h1000, 3'b000), 0, 0, 1, 32'hFFFF_F000, "R4 min");
        drive(32'h0001_0000, enc_b(13'h0FFC, 3'b000), 0, 0, 1, 32'h0000_0FFC, "R4 max");
        drive(32'h0001_0000, enc_b(13'h1A54, 3'b000), 0, 0, 1, 32'hFFFF_FA54, "R4 mixed");

        // R5: direct jumps
        drive(32'h0004_0000, enc_j(21'h0FFFFC), 0, 0, 2, 32'h000F_FFFC, "R5 max");
        drive(32'h0040_0000, enc_j(21'h100000), 0, 0, 2, 32'hFFF0_0000, "R5 min");
        drive(32'h0004_0000, enc_j(21'h0A5A5C), 0, 0, 2, 32'h000A_5A5C, "R5 mixed");

        // R6: indirect jumps, bit 0 cleared
        drive(32'h300, enc_r(12'h7FF, 3'b000), 32'h0000_1001, 0, 3, 32'h0000_07FF, "R6 clear bit0");
        drive(32'h300, enc_r(12'h800, 3'b000), 32'h0000_2000, 0, 3, 32'hFFFF_F800, "R6 negative");

        // R8 / R9: halfword-aligned targets
        drive(32'h400, enc_b(13'd6, 3'b000), 1, 1, 1, 6, "R8 R9 branch half");
        drive(32'h400, enc_b(13'd6, 3'b000), 1, 2, 1, 6, "R8 not taken no fault");
        drive(32'h400, enc_j(21'd10), 0, 0, 2, 10, "R8 R9 jump half");
        drive(32'h400, enc_r(12'h003, 3'b000), 32'h1000, 0, 3, 3, "R8 R9 indirect half");

        // R10: back-to-back different results
        drive(32'h500, enc_j(21'd8), 0, 0, 2, 8, "R10 b2b a");
        drive(32'h504, 32'h13, 0, 0, 0, 0, "R10 b2b b");

        @(negedge clk);
        @(negedge clk);
        if (sbq.size() != 0) begin
            fails++;
            $display("FAIL R10: got %0d pending expected 0", sbq.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule